// File: doc/BRIEF.md
# Tree-Based Job Load Balancer

This block holds a small LIFO stack of job words for each of a handful of cores and keeps the stacks evenly filled. Each core pushes new jobs onto its own stack and pops jobs to process them. A pop answers one cycle later with a data word and a valid flag. At the same time, a combinational reduction tree compares the job counts of all healthy nodes. It picks the most-loaded node as the source and the least-loaded node as the destination. In the same clock edge it moves the source's top job word onto the destination's stack.

A core that has been marked faulty is bypassed. Its node is never chosen as source or destination, so its stack is left out of balancing. Its local push and pop stay usable. A move takes place only when the count gap between the two chosen nodes is at least two, which keeps a single job from bouncing back and forth. A local push or pop on either chosen node holds the move off for that cycle. An active-low reset clears all counts. The reset is asserted asynchronously and released through a two-flop synchronizer.

Top module: `job_balancer`

## Requirements
- R1: After reset every count is 0 and every full flag, response valid and transfer indication is low. A pop on a non-empty stack gives, in the next cycle, pop_valid high and the most recently stored word (last in, first out). Counts are NODES fields of CNT_W bits, with node k at bits [k*CNT_W +: CNT_W]. Data words are packed the same way with DATA_W bits.
- R2: A transfer lowers the source count by 1 and raises the destination count by 1 at the next edge. The word moved is the source's top word, and it becomes the destination's top word.
- R3: A transfer happens only when the largest healthy count exceeds the smallest healthy count by at least 2. With a smaller gap, no count changes.
- R4: The source is a healthy node with the largest count and the destination is a healthy node with the smallest count. Ties go to the lowest node index. xfer_src_o and xfer_dst_o are binary node indices that are meaningful while xfer_o is high. xfer_o shows the move that the coming edge performs.
- R5: A node whose faulty_i bit is 1 is never source or destination, whatever its count.
- R6: If the chosen source or destination has push_i or pop_i high in the same cycle, no transfer occurs in that cycle.
- R7: A push to a stack holding DEPTH words is refused. full_o for that node is high, the count stays at DEPTH, and the stored words are unchanged.
- R8: A pop on an empty stack gives pop_valid low in the next cycle.
- R9: When fewer than two nodes are healthy, no transfer occurs.
- R10: Push and pop together on a non-empty stack return the current top word and put the pushed word in its place, with the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| push_i | input | NODES | Per-node push request |
| push_data_i | input | NODES*DATA_W | Per-node job word to push |
| pop_i | input | NODES | Per-node pop request |
| faulty_i | input | NODES | Per-node core-faulty flag (bypass) |
| pop_valid_o | output | NODES | Pop response valid, one cycle after pop |
| pop_data_o | output | NODES*DATA_W | Pop response word |
| full_o | output | NODES | Stack holds DEPTH words |
| count_o | output | NODES*CNT_W | Per-node job count |
| xfer_o | output | 1 | A job moves at the coming edge |
| xfer_src_o | output | IDX_W | Source node index |
| xfer_dst_o | output | IDX_W | Destination node index |

## Verification
A wrong reduction tree shows up in the same cycle. xfer_src_o or xfer_dst_o names a node that is not the extreme one, or that is faulty, while xfer_o is high. A bad gap test makes xfer_o rise on a gap of one. A corrupt count or stack pointer shows up on count_o one edge later. A misplaced write reaches the ports only through pop_data_o, one cycle after the pop that reads it. For that reason every moved or refused word is read back by popping it.

// File: rtl/jb_pkg.sv
package jb_pkg;
  typedef enum logic {SEL_MAX = 1'b0, SEL_MIN = 1'b1} sel_mode_e;
endpackage

// File: rtl/jb_rst_sync.sv
module jb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/jb_stack.sv
module jb_stack #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              xin_i,
  input  logic [DATA_W-1:0] xin_data_i,
  input  logic              xout_i,
  output logic [DATA_W-1:0] top_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o,
  output logic              rsp_vld_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rsp_vld_q, rsp_vld_d;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_en;
  logic              pop_ok, push_ok, empty, full;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  top_ptr;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign top_ptr = cnt_q - CNT_W'(1);
  assign top_o   = mem[AW'(top_ptr)];

  // next-state
  always_comb begin
    pop_ok  = pop_i && !empty;
    push_ok = push_i && (!full || pop_ok);
    cnt_d   = cnt_q;
    if (push_ok) cnt_d = cnt_d + CNT_W'(1);
    if (pop_ok)  cnt_d = cnt_d - CNT_W'(1);
    if (xin_i)   cnt_d = cnt_d + CNT_W'(1);
    if (xout_i)  cnt_d = cnt_d - CNT_W'(1);
    wr_en   = push_ok || xin_i;
    if (push_ok) begin
      wr_addr = pop_ok ? AW'(top_ptr) : AW'(cnt_q);
      wr_data = push_data_i;
    end else begin
      wr_addr = AW'(cnt_q);
      wr_data = xin_data_i;
    end
    rsp_vld_d = pop_ok;
    rsp_en    = pop_ok;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      rsp_vld_q  <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      cnt_q     <= cnt_d;
      rsp_vld_q <= rsp_vld_d;
      if (rsp_en) rsp_data_q <= top_o;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign cnt_o      = cnt_q;
  assign full_o     = full;
  assign rsp_vld_o  = rsp_vld_q;
  assign rsp_data_o = rsp_data_q;
endmodule

// File: rtl/jb_sel_tree.sv
module jb_sel_tree
  import jb_pkg::*;
#(
  parameter int        NODES = 8,
  parameter int        CNT_W = 4,
  parameter int        IDX_W = $clog2(NODES),
  parameter sel_mode_e MODE  = SEL_MAX
) (
  input  logic [NODES-1:0]       vld_i,
  input  logic [NODES*CNT_W-1:0] cnt_i,
  output logic                   vld_o,
  output logic [CNT_W-1:0]       cnt_o,
  output logic [IDX_W-1:0]       idx_o
);
  localparam int LEAVES = 1 << IDX_W;
  localparam int HEAP   = 2 * LEAVES - 1;

  logic             hv [HEAP];
  logic [CNT_W-1:0] hc [HEAP];
  logic [IDX_W-1:0] hi [HEAP];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < NODES) begin : g_real
      assign hv[LEAVES-1+k] = vld_i[k];
      assign hc[LEAVES-1+k] = cnt_i[k*CNT_W +: CNT_W];
    end else begin : g_pad
      assign hv[LEAVES-1+k] = 1'b0;
      assign hc[LEAVES-1+k] = '0;
    end
    assign hi[LEAVES-1+k] = IDX_W'(k);
  end

  // The left child always covers lower indices, so preferring it on a tie
  // gives the lowest-index winner.
  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    logic better;
    logic take_left;
    if (MODE == SEL_MAX) begin : g_max
      assign better = (hc[2*n+1] >= hc[2*n+2]);
    end else begin : g_min
      assign better = (hc[2*n+1] <= hc[2*n+2]);
    end
    assign take_left = hv[2*n+1] && (!hv[2*n+2] || better);
    assign hv[n] = hv[2*n+1] || hv[2*n+2];
    assign hc[n] = take_left ? hc[2*n+1] : hc[2*n+2];
    assign hi[n] = take_left ? hi[2*n+1] : hi[2*n+2];
  end

  assign vld_o = hv[0];
  assign cnt_o = hc[0];
  assign idx_o = hi[0];
endmodule

// File: rtl/jb_switch.sv
module jb_switch #(
  parameter int NODES  = 8,
  parameter int CNT_W  = 4,
  parameter int IDX_W  = $clog2(NODES),
  parameter int DATA_W = 16
) (
  input  logic                    max_vld_i,
  input  logic [CNT_W-1:0]        max_cnt_i,
  input  logic [IDX_W-1:0]        max_idx_i,
  input  logic                    min_vld_i,
  input  logic [CNT_W-1:0]        min_cnt_i,
  input  logic [IDX_W-1:0]        min_idx_i,
  input  logic [NODES-1:0]        busy_i,
  input  logic [NODES*DATA_W-1:0] top_i,
  output logic                    xfer_o,
  output logic [IDX_W-1:0]        src_o,
  output logic [IDX_W-1:0]        dst_o,
  output logic [DATA_W-1:0]       data_o,
  output logic [NODES-1:0]        out_oh_o,
  output logic [NODES-1:0]        in_oh_o
);
  logic [CNT_W:0] hi_ext, lo_ext;
  logic           gap_ok, ends_free;

  always_comb begin
    hi_ext    = {1'b0, max_cnt_i};
    lo_ext    = {1'b0, min_cnt_i} + (CNT_W+1)'(2);
    gap_ok    = max_vld_i && min_vld_i && (hi_ext >= lo_ext);
    ends_free = !busy_i[max_idx_i] && !busy_i[min_idx_i];
    xfer_o    = gap_ok && ends_free;
    data_o    = '0;
    out_oh_o  = '0;
    in_oh_o   = '0;
    for (int k = 0; k < NODES; k++) begin
      if (IDX_W'(k) == max_idx_i) data_o = top_i[k*DATA_W +: DATA_W];
      out_oh_o[k] = xfer_o && (IDX_W'(k) == max_idx_i);
      in_oh_o[k]  = xfer_o && (IDX_W'(k) == min_idx_i);
    end
  end

  assign src_o = max_idx_i;
  assign dst_o = min_idx_i;
endmodule

// File: rtl/job_balancer.sv
module job_balancer
  import jb_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int IDX_W  = $clog2(NODES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NODES-1:0]        push_i,
  input  logic [NODES*DATA_W-1:0] push_data_i,
  input  logic [NODES-1:0]        pop_i,
  input  logic [NODES-1:0]        faulty_i,
  output logic [NODES-1:0]        pop_valid_o,
  output logic [NODES*DATA_W-1:0] pop_data_o,
  output logic [NODES-1:0]        full_o,
  output logic [NODES*CNT_W-1:0]  count_o,
  output logic                    xfer_o,
  output logic [IDX_W-1:0]        xfer_src_o,
  output logic [IDX_W-1:0]        xfer_dst_o
);
  logic                    rst_n_s;
  logic [NODES*DATA_W-1:0] tops;
  logic [NODES-1:0]        out_oh, in_oh, healthy, busy;
  logic [DATA_W-1:0]       move_data;
  logic                    max_vld, min_vld;
  logic [CNT_W-1:0]        max_cnt, min_cnt;
  logic [IDX_W-1:0]        max_idx, min_idx;

  assign healthy = ~faulty_i;
  assign busy    = push_i | pop_i;

  jb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s));

  for (genvar k = 0; k < NODES; k++) begin : g_node
    jb_stack #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_stack (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .push_i     (push_i[k]),
      .push_data_i(push_data_i[k*DATA_W +: DATA_W]),
      .pop_i      (pop_i[k]),
      .xin_i      (in_oh[k]),
      .xin_data_i (move_data),
      .xout_i     (out_oh[k]),
      .top_o      (tops[k*DATA_W +: DATA_W]),
      .cnt_o      (count_o[k*CNT_W +: CNT_W]),
      .full_o     (full_o[k]),
      .rsp_vld_o  (pop_valid_o[k]),
      .rsp_data_o (pop_data_o[k*DATA_W +: DATA_W])
    );
  end

  jb_sel_tree #(.NODES(NODES), .CNT_W(CNT_W), .IDX_W(IDX_W), .MODE(SEL_MAX)) u_max (
    .vld_i(healthy), .cnt_i(count_o), .vld_o(max_vld), .cnt_o(max_cnt), .idx_o(max_idx)
  );

  jb_sel_tree #(.NODES(NODES), .CNT_W(CNT_W), .IDX_W(IDX_W), .MODE(SEL_MIN)) u_min (
    .vld_i(healthy), .cnt_i(count_o), .vld_o(min_vld), .cnt_o(min_cnt), .idx_o(min_idx)
  );

  jb_switch #(.NODES(NODES), .CNT_W(CNT_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_sw (
    .max_vld_i(max_vld), .max_cnt_i(max_cnt), .max_idx_i(max_idx),
    .min_vld_i(min_vld), .min_cnt_i(min_cnt), .min_idx_i(min_idx),
    .busy_i(busy), .top_i(tops),
    .xfer_o(xfer_o), .src_o(xfer_src_o), .dst_o(xfer_dst_o),
    .data_o(move_data), .out_oh_o(out_oh), .in_oh_o(in_oh)
  );
endmodule

// File: rtl/jb_checker.sv
module jb_checker #(
  parameter int NODES  = 8,
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4,
  parameter int IDX_W  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NODES-1:0]        push_i,
  input logic [NODES-1:0]        pop_i,
  input logic [NODES-1:0]        faulty_i,
  input logic [NODES-1:0]        pop_valid_o,
  input logic [NODES*CNT_W-1:0]  count_o,
  input logic                    xfer_o,
  input logic [IDX_W-1:0]        xfer_src_o,
  input logic [IDX_W-1:0]        xfer_dst_o
);
  logic [CNT_W-1:0] ca [NODES];
  logic             src_is_max, dst_is_min;

  for (genvar k = 0; k < NODES; k++) begin : g_unpack
    assign ca[k] = count_o[k*CNT_W +: CNT_W];
  end

  always_comb begin
    src_is_max = 1'b1;
    dst_is_min = 1'b1;
    for (int k = 0; k < NODES; k++) begin
      if (!faulty_i[k]) begin
        if (ca[k] > ca[xfer_src_o]) src_is_max = 1'b0;
        if ((k < int'(xfer_src_o)) && (ca[k] == ca[xfer_src_o])) src_is_max = 1'b0;
        if (ca[k] < ca[xfer_dst_o]) dst_is_min = 1'b0;
        if ((k < int'(xfer_dst_o)) && (ca[k] == ca[xfer_dst_o])) dst_is_min = 1'b0;
      end
    end
  end

  AST_XFER_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |-> (!faulty_i[xfer_src_o] && !faulty_i[xfer_dst_o])); // R5
  AST_XFER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |-> ({1'b0, ca[xfer_src_o]} >= {1'b0, ca[xfer_dst_o]} + (CNT_W+1)'(2))); // R3
  AST_XFER_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |-> (!push_i[xfer_src_o] && !pop_i[xfer_src_o] &&
                !push_i[xfer_dst_o] && !pop_i[xfer_dst_o])); // R6
  AST_XFER_SRC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |=> (ca[$past(xfer_src_o)] == $past(ca[xfer_src_o]) - CNT_W'(1))); // R2
  AST_XFER_DST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |=> (ca[$past(xfer_dst_o)] == $past(ca[xfer_dst_o]) + CNT_W'(1))); // R2
  AST_SRC_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |-> src_is_max); // R4
  AST_DST_IS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |-> dst_is_min); // R4
  AST_FEW_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~faulty_i) < 2) |-> !xfer_o); // R9

  for (genvar k = 0; k < NODES; k++) begin : g_node_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ca[k] <= CNT_W'(DEPTH)); // R7
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i[k] && (ca[k] == '0)) |=> !pop_valid_o[k]); // R8
  end
endmodule

bind job_balancer jb_checker #(
  .NODES(NODES), .DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .faulty_i(faulty_i),
  .pop_valid_o(pop_valid_o), .count_o(count_o), .xfer_o(xfer_o),
  .xfer_src_o(xfer_src_o), .xfer_dst_o(xfer_dst_o)
);

// File: tb/job_balancer_tb.sv
`timescale 1ns/1ps
module job_balancer_tb;
  localparam int NODES  = 8;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 16;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int IDX_W  = $clog2(NODES);

  logic                    clk;
  logic                    rst_n;
  logic [NODES-1:0]        push_i, pop_i, faulty_i;
  logic [NODES*DATA_W-1:0] push_data_i;
  logic [NODES-1:0]        pop_valid_o, full_o;
  logic [NODES*DATA_W-1:0] pop_data_o;
  logic [NODES*CNT_W-1:0]  count_o;
  logic                    xfer_o;
  logic [IDX_W-1:0]        xfer_src_o, xfer_dst_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  job_balancer #(.NODES(NODES), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .faulty_i(faulty_i), .pop_valid_o(pop_valid_o),
    .pop_data_o(pop_data_o), .full_o(full_o), .count_o(count_o),
    .xfer_o(xfer_o), .xfer_src_o(xfer_src_o), .xfer_dst_o(xfer_dst_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int cnt_of(int k);
    return int'(count_o[k*CNT_W +: CNT_W]);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(int k, int data);
    push_i[k] = 1'b1;
    push_data_i[k*DATA_W +: DATA_W] = DATA_W'(data);
    step();
    push_i[k] = 1'b0;
  endtask

  task automatic pop_expect(string req, int k, int vld, int data);
    pop_i[k] = 1'b1;
    step();
    pop_i[k] = 1'b0;
    chk(req, "pop valid", int'(pop_valid_o[k]), vld);
    if (vld != 0) chk(req, "pop data", int'(pop_data_o[k*DATA_W +: DATA_W]), data);
  endtask

  task automatic t_reset();
    for (int k = 0; k < NODES; k++) chk("R1", "reset count", cnt_of(k), 0);
    chk("R1", "reset full", int'(full_o), 0);
    chk("R1", "reset valid", int'(pop_valid_o), 0);
    chk("R1", "reset xfer", int'(xfer_o), 0);
  endtask

  task automatic t_lifo();
    push(0, 16'h0a01); push(0, 16'h0a02); push(0, 16'h0a03);
    chk("R1", "count after 3 pushes", cnt_of(0), 3);
    pop_expect("R1", 0, 1, 16'h0a03);
    pop_expect("R1", 0, 1, 16'h0a02);
    pop_expect("R1", 0, 1, 16'h0a01);
    pop_expect("R8", 0, 0, 0);
    chk("R8", "count after empty pop", cnt_of(0), 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) push(1, 16'h1100 + i);
    chk("R7", "full flag", int'(full_o[1]), 1);
    push(1, 16'h1bad);
    chk("R7", "count after refused push", cnt_of(1), DEPTH);
    pop_expect("R7", 1, 1, 16'h1100 + DEPTH - 1);
    chk("R7", "full flag cleared", int'(full_o[1]), 0);
    for (int i = DEPTH - 2; i >= 0; i--) pop_expect("R7", 1, 1, 16'h1100 + i);
  endtask

  task automatic t_pushpop();
    push(2, 16'h2201);
    push_i[2] = 1'b1; push_data_i[2*DATA_W +: DATA_W] = 16'h2202; pop_i[2] = 1'b1;
    step();
    push_i[2] = 1'b0; pop_i[2] = 1'b0;
    chk("R10", "pop valid", int'(pop_valid_o[2]), 1);
    chk("R10", "old top returned", int'(pop_data_o[2*DATA_W +: DATA_W]), 16'h2201);
    chk("R10", "count unchanged", cnt_of(2), 1);
    pop_expect("R10", 2, 1, 16'h2202);
  endtask

  task automatic t_xfer();
    push(3, 16'h0030); push(3, 16'h0031); push(3, 16'h0032);
    faulty_i = '0;
    #1;
    chk("R4", "xfer raised", int'(xfer_o), 1);
    chk("R4", "source index", int'(xfer_src_o), 3);
    chk("R4", "destination lowest tie", int'(xfer_dst_o), 0);
    @(posedge clk); @(negedge clk);
    faulty_i = '1;
    #1;
    chk("R2", "source count", cnt_of(3), 2);
    chk("R2", "destination count", cnt_of(0), 1);
    pop_expect("R2", 0, 1, 16'h0032);
    pop_expect("R2", 3, 1, 16'h0031);
    pop_expect("R2", 3, 1, 16'h0030);
  endtask

  task automatic t_gap();
    push(4, 16'h0040);
    faulty_i = '0;
    #1;
    chk("R3", "no xfer on gap 1", int'(xfer_o), 0);
    @(posedge clk); @(negedge clk);
    faulty_i = '1;
    chk("R3", "node4 count kept", cnt_of(4), 1);
    chk("R3", "node0 count kept", cnt_of(0), 0);
    pop_expect("R3", 4, 1, 16'h0040);
  endtask

  task automatic t_fault();
    push(5, 16'h0050); push(5, 16'h0051); push(5, 16'h0052);
    faulty_i = 8'b1001_1111;
    #1;
    chk("R5", "xfer between healthy", int'(xfer_o), 1);
    chk("R5", "source", int'(xfer_src_o), 5);
    chk("R5", "destination skips faulty", int'(xfer_dst_o), 6);
    faulty_i = 8'b0010_0000;
    #1;
    chk("R5", "overloaded faulty node ignored", int'(xfer_o), 0);
    faulty_i = 8'b1101_1111;
    #1;
    chk("R9", "single healthy node", int'(xfer_o), 0);
    @(posedge clk); @(negedge clk);
    chk("R9", "node5 count kept", cnt_of(5), 3);
    faulty_i = '1;
  endtask

  task automatic t_busy();
    faulty_i = 8'b1001_1111;
    push_i[6] = 1'b1; push_data_i[6*DATA_W +: DATA_W] = 16'h0060;
    #1;
    chk("R6", "xfer held by local push", int'(xfer_o), 0);
    @(posedge clk); @(negedge clk);
    push_i[6] = 1'b0;
    faulty_i = '1;
    chk("R6", "source count kept", cnt_of(5), 3);
    chk("R6", "destination only pushed", cnt_of(6), 1);
    pop_expect("R6", 6, 1, 16'h0060);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; push_i = '0; pop_i = '0; faulty_i = '1; push_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_lifo();
    t_full();
    t_pushpop();
    t_xfer();
    t_gap();
    t_fault();
    t_busy();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule